// File: doc/BRIEF.md
# Integer Compare-and-Set Unit

This execution unit compares a 32-bit operand A against a second operand B and writes a 32-bit Boolean result. B comes from one of three places: a register value, a word fetched from a constant bank, or a 20-bit immediate that the unit sign-extends. The relational test can be signed or unsigned. The unit then merges the test outcome with a 1-bit predicate, which may be inverted, using AND, OR or XOR. The merged bit is written out in one of two encodings: an all-ones mask, or the single-precision encoding of 1.0. A false outcome gives zero in both encodings.

An extended mode lets the unit finish a multi-word compare. A separate adder first subtracts the low words and produces carry and zero flags. This unit then compares the high words, using the incoming carry as the borrow and ANDing its own zero test with the incoming zero flag. The unit can optionally write a four-bit condition-code value derived from the result. A request is accepted on `in_valid`, and the registered result appears one cycle later with `out_valid`. Operand fetch, constant storage and the predicate file sit outside the block.

Top module: `icmp_set_unit`

## Requirements
- R1: Test codes are 0 F, 1 LT, 2 EQ, 3 LE, 4 GT, 5 NE, 6 GE, 7 T, 8 LO, 9 LS, 10 HI, 11 HS. With `fmt_sel` 0 (default) or 3, codes 0 to 7 compare signed. Codes 8 to 11 (lower, lower-or-same, higher, higher-or-same) always compare unsigned.
- R2: `fmt_sel` 1 makes codes 0 to 7 compare as unsigned 32-bit values. `fmt_sel` 2 makes them compare as signed.
- R3: A request is illegal in two cases: `fmt_sel` 2 combined with codes 8 to 11, or any test code 12 to 15. An illegal request raises `out_illegal` with `out_valid`, writes a result of 0 and leaves `cc_out` unchanged.
- R4: With `float_mode` 0 a true outcome writes 0xFFFFFFFF. With `float_mode` 1 it writes 0x3F800000. A false outcome writes 0 in both modes.
- R5: The merged outcome is (A test B) op P. P is `pred_in`, inverted when `pred_inv` is 1. `bool_op` selects the operation: 1 AND, 2 OR, 3 XOR. `bool_op` 0 behaves as AND with a true predicate.
- R6: `opb_sel` 0 (or 3) takes B from `opb_reg`, 1 takes it from `opb_const`, and 2 takes the 20-bit `opb_imm` sign-extended to 32 bits.
- R7: Code F is always false and code T is always true, whatever the operands.
- R8: With `ext_mode` 1 the difference is A + ~B + C, where C is `cc_in[1]`. The zero test is true only when that difference is zero and `cc_in[2]` is 1. LT/LO use the sign/overflow or borrow of that difference, so LE on the high words completes a 64-bit compare. With `ext_mode` 0, `cc_in` has no effect.
- R9: When a legal request has `cc_we` 1, `cc_out` becomes {sign = outcome, zero = not outcome, carry = 0, overflow = 0}, with bit order [3] sign, [2] zero, [1] carry, [0] overflow. Otherwise `cc_out` holds its value.
- R10: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. `out_result` and `out_illegal` hold their values when no request arrives.
- R11: While and after reset, `out_valid`, `out_result`, `out_illegal` and `cc_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| test_code | input | 4 | Relational test selector |
| fmt_sel | input | 2 | Compare format: 0 default, 1 unsigned, 2 signed, 3 default |
| opa | input | 32 | Operand A |
| opb_reg | input | 32 | Register value for B |
| opb_const | input | 32 | Constant-bank word for B |
| opb_imm | input | 20 | Immediate for B, sign-extended |
| opb_sel | input | 2 | B source selector |
| bool_op | input | 2 | Predicate merge: 0 none, 1 AND, 2 OR, 3 XOR |
| pred_in | input | 1 | Predicate bit |
| pred_inv | input | 1 | Invert predicate |
| float_mode | input | 1 | 0 mask result, 1 FP32 1.0 result |
| ext_mode | input | 1 | Extended multi-word compare |
| cc_in | input | 4 | Incoming flags {sign, zero, carry, overflow} |
| cc_we | input | 1 | Write condition codes |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Destination value |
| out_illegal | output | 1 | Illegal format/test combination |
| cc_out | output | 4 | Condition-code register {sign, zero, carry, overflow} |

## Verification
The checker's properties relate each output cycle to the request registered one edge earlier. They therefore assume that `in_valid` and all its companion fields are steady through that edge, and that `in_valid` is low during reset. The bench drives every field on the falling edge and drops `in_valid` in the following falling edge, so each request is seen by exactly one rising edge. It also holds `in_valid` low until reset is released. The extended-mode vectors use flag values that a real low-word subtraction would produce, so the 64-bit meaning of each high-word result can be stated directly.

// File: rtl/icmp_pkg.sv
package icmp_pkg;

   // Test code values (order matters: codes 8..11 are unsigned-only)
   localparam logic [3:0] TST_F  = 4'd0;
   localparam logic [3:0] TST_LT = 4'd1;
   localparam logic [3:0] TST_EQ = 4'd2;
   localparam logic [3:0] TST_LE = 4'd3;
   localparam logic [3:0] TST_GT = 4'd4;
   localparam logic [3:0] TST_NE = 4'd5;
   localparam logic [3:0] TST_GE = 4'd6;
   localparam logic [3:0] TST_T  = 4'd7;
   localparam logic [3:0] TST_LO = 4'd8;
   localparam logic [3:0] TST_LS = 4'd9;
   localparam logic [3:0] TST_HI = 4'd10;
   localparam logic [3:0] TST_HS = 4'd11;

   // Condition-code bit positions
   localparam int CC_SIGN  = 3;
   localparam int CC_ZERO  = 2;
   localparam int CC_CARRY = 1;
   localparam int CC_OVF   = 0;

   typedef enum logic [1:0] {
      FMT_DEFAULT = 2'd0,
      FMT_UNS     = 2'd1,
      FMT_SGN     = 2'd2,
      FMT_DEF_ALT = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      BSRC_REG   = 2'd0,
      BSRC_CONST = 2'd1,
      BSRC_IMM   = 2'd2,
      BSRC_REG_ALT = 2'd3
   } bsrc_e;

   typedef enum logic [1:0] {
      BOP_NONE = 2'd0,
      BOP_AND  = 2'd1,
      BOP_OR   = 2'd2,
      BOP_XOR  = 2'd3
   } bop_e;

   typedef struct packed {
      logic neg;
      logic ovf;
      logic carry;
      logic zero;
   } flags_t;

endpackage

// File: rtl/icmp_operand_sel.sv
module icmp_operand_sel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 20
) (
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [DATA_W-1:0] const_val,
   input  logic [IMM_W-1:0]  imm_val,
   output logic [DATA_W-1:0] opb
);
   import icmp_pkg::*;

   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (EXT_W == 0) begin : g_imm_full
         assign imm_ext = imm_val;
      end else begin : g_imm_sext
         assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
      end
   endgenerate

   always_comb begin
      unique case (bsrc_e'(sel))
         BSRC_CONST: opb = const_val;
         BSRC_IMM:   opb = imm_ext;
         default:    opb = reg_val;
      endcase
   end

endmodule

// File: rtl/icmp_flag_core.sv
module icmp_flag_core #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              ext,
   input  logic              carry_in,
   input  logic              zero_in,
   output icmp_pkg::flags_t  flags
);
   import icmp_pkg::*;

   localparam int SUM_W = DATA_W + 1;

   logic              cin_eff;
   logic [SUM_W-1:0]  sum;
   logic [DATA_W-1:0] diff;

   // Plain compare subtracts with no borrow; extended mode borrows via carry.
   assign cin_eff = ext ? carry_in : 1'b1;
   assign sum     = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, cin_eff};
   assign diff    = sum[DATA_W-1:0];

   always_comb begin
      flags.neg   = diff[DATA_W-1];
      flags.carry = sum[DATA_W];
      flags.ovf   = (a[DATA_W-1] != b[DATA_W-1]) && (diff[DATA_W-1] != a[DATA_W-1]);
      flags.zero  = (diff == '0) && (ext ? zero_in : 1'b1);
   end

endmodule

// File: rtl/icmp_test_eval.sv
module icmp_test_eval (
   input  logic [3:0]       test_code,
   input  logic [1:0]       fmt_sel,
   input  icmp_pkg::flags_t flags,
   output logic             outcome,
   output logic             illegal
);
   import icmp_pkg::*;

   logic uns_only;
   logic reserved;
   logic use_signed;
   logic lt;
   logic z;

   assign uns_only   = (test_code >= TST_LO) && (test_code <= TST_HS);
   assign reserved   = (test_code > TST_HS);
   assign use_signed = !uns_only && (fmt_e'(fmt_sel) != FMT_UNS);
   assign illegal    = reserved || (uns_only && (fmt_e'(fmt_sel) == FMT_SGN));

   assign lt = use_signed ? (flags.neg ^ flags.ovf) : !flags.carry;
   assign z  = flags.zero;

   always_comb begin
      unique case (test_code)
         TST_F:          outcome = 1'b0;
         TST_LT, TST_LO: outcome = lt;
         TST_EQ:         outcome = z;
         TST_LE, TST_LS: outcome = lt || z;
         TST_GT, TST_HI: outcome = !lt && !z;
         TST_NE:         outcome = !z;
         TST_GE, TST_HS: outcome = !lt;
         TST_T:          outcome = 1'b1;
         default:        outcome = 1'b0;
      endcase
   end

endmodule

// File: rtl/icmp_set_unit.sv
module icmp_set_unit #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        test_code,
   input  logic [1:0]        fmt_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb_reg,
   input  logic [DATA_W-1:0] opb_const,
   input  logic [IMM_W-1:0]  opb_imm,
   input  logic [1:0]        opb_sel,
   input  logic [1:0]        bool_op,
   input  logic              pred_in,
   input  logic              pred_inv,
   input  logic              float_mode,
   input  logic              ext_mode,
   input  logic [3:0]        cc_in,
   input  logic              cc_we,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_illegal,
   output logic [3:0]        cc_out
);
   import icmp_pkg::*;

   initial begin
      if (IMM_W < 1 || IMM_W > DATA_W)
         $error("icmp_set_unit: IMM_W must lie in 1..DATA_W");
      if (DATA_W != 32 && DATA_W != 64)
         $error("icmp_set_unit: DATA_W must be 32 or 64");
   end

   localparam logic [DATA_W-1:0] MASK_TRUE = '1;

   logic [DATA_W-1:0] fp_one;

   generate
      if (DATA_W == 64) begin : g_fp64
         assign fp_one = 64'h3FF0_0000_0000_0000;
      end else begin : g_fp32
         assign fp_one = DATA_W'(32'h3F80_0000);
      end
   endgenerate

   logic [DATA_W-1:0] opb;
   flags_t            flags;
   logic              cmp_true;
   logic              bad_req;
   logic              pred_eff;
   logic              merged;
   logic              set_bit;
   logic [DATA_W-1:0] value_nxt;

   icmp_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .sel       (opb_sel),
      .reg_val   (opb_reg),
      .const_val (opb_const),
      .imm_val   (opb_imm),
      .opb       (opb)
   );

   icmp_flag_core #(.DATA_W(DATA_W)) u_flags (
      .a        (opa),
      .b        (opb),
      .ext      (ext_mode),
      .carry_in (cc_in[CC_CARRY]),
      .zero_in  (cc_in[CC_ZERO]),
      .flags    (flags)
   );

   icmp_test_eval u_eval (
      .test_code (test_code),
      .fmt_sel   (fmt_sel),
      .flags     (flags),
      .outcome   (cmp_true),
      .illegal   (bad_req)
   );

   assign pred_eff = pred_in ^ pred_inv;

   always_comb begin
      unique case (bop_e'(bool_op))
         BOP_AND: merged = cmp_true & pred_eff;
         BOP_OR:  merged = cmp_true | pred_eff;
         BOP_XOR: merged = cmp_true ^ pred_eff;
         default: merged = cmp_true;
      endcase
   end

   assign set_bit   = merged && !bad_req;
   assign value_nxt = !set_bit  ? '0 :
                      float_mode ? fp_one : MASK_TRUE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_illegal <= 1'b0;
         cc_out      <= 4'b0000;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= value_nxt;
            out_illegal <= bad_req;
            if (cc_we && !bad_req) begin
               cc_out[CC_SIGN]  <= set_bit;
               cc_out[CC_ZERO]  <= !set_bit;
               cc_out[CC_CARRY] <= 1'b0;
               cc_out[CC_OVF]   <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/icmp_set_unit_chk.sv
module icmp_set_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        test_code,
   input logic [1:0]        bool_op,
   input logic              float_mode,
   input logic              cc_we,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic              out_illegal,
   input logic [3:0]        cc_out
);

   // R10: strobe follows the request by one edge
   p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R10: no request, no change to the result
   p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(out_result) && $stable(out_illegal));

   // R4: mask encoding is all-zero or all-one
   p_mask_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !$past(float_mode) |-> (out_result == '0) || (&out_result));

   // R4: float encoding never produces the all-ones mask
   p_float_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(float_mode) |-> !(&out_result));

   // R3: illegal request yields zero
   p_illegal_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_illegal |-> out_result == '0);

   // R9: flag write mirrors the result
   p_cc_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(cc_we) && !out_illegal |->
         cc_out == {(out_result != '0), (out_result == '0), 2'b00});

   // R9: flags hold without an accepted legal write
   p_cc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(in_valid) && $past(cc_we)) || out_illegal |-> $stable(cc_out));

   // R7: F under AND/none can never be true
   p_false_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(test_code) == 4'd0 && $past(bool_op) <= 2'd1 |-> out_result == '0);

   // R7: T with no predicate is always true
   p_true_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(test_code) == 4'd7 && $past(bool_op) == 2'd0 |-> out_result != '0);

endmodule

bind icmp_set_unit icmp_set_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .test_code   (test_code),
   .bool_op     (bool_op),
   .float_mode  (float_mode),
   .cc_we       (cc_we),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_illegal (out_illegal),
   .cc_out      (cc_out)
);

// File: tb/test_icmp_set_unit.sv
`timescale 1ns/1ps
module test_icmp_set_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  test_code = '0;
   logic [1:0]  fmt_sel = '0;
   logic [31:0] opa = '0, opb_reg = '0, opb_const = '0;
   logic [19:0] opb_imm = '0;
   logic [1:0]  opb_sel = '0, bool_op = '0;
   logic        pred_in = 1'b0, pred_inv = 1'b0, float_mode = 1'b0, ext_mode = 1'b0;
   logic [3:0]  cc_in = '0;
   logic        cc_we = 1'b0;
   logic        out_valid, out_illegal;
   logic [31:0] out_result;
   logic [3:0]  cc_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   icmp_set_unit i_icmp_set_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .test_code(test_code),
      .fmt_sel(fmt_sel), .opa(opa), .opb_reg(opb_reg), .opb_const(opb_const),
      .opb_imm(opb_imm), .opb_sel(opb_sel), .bool_op(bool_op), .pred_in(pred_in),
      .pred_inv(pred_inv), .float_mode(float_mode), .ext_mode(ext_mode),
      .cc_in(cc_in), .cc_we(cc_we), .out_valid(out_valid), .out_result(out_result),
      .out_illegal(out_illegal), .cc_out(cc_out)
   );

   localparam logic [31:0] M  = 32'hFFFF_FFFF;
   localparam logic [31:0] F1 = 32'h3F80_0000;

   typedef struct packed {
      logic [3:0]  tst;
      logic [1:0]  fmt;
      logic [31:0] a;
      logic [31:0] b;
      logic [1:0]  bsel;
      logic [19:0] imm;
      logic [1:0]  bop;
      logic        pr;
      logic        pinv;
      logic        flt;
      logic        ext;
      logic [3:0]  ccin;
      logic [7:0]  rq;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VECS [NV] = '{
      // R1 signed default, then forced unsigned
      '{4'd1, 2'd0, 32'hFFFF_FFFF, 32'h1, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd1, M},
      '{4'd8, 2'd0, 32'hFFFF_FFFF, 32'h1, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd1, 32'h0},
      // R2 explicit unsigned
      '{4'd1, 2'd1, 32'h1, 32'hFFFF_FFFF, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd2, M},
      '{4'd1, 2'd0, 32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd1, M},
      // R4 float encoding
      '{4'd4, 2'd0, 32'h7FFF_FFFF, 32'h8000_0000, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd4, F1},
      // R6 constant and immediate sources
      '{4'd2, 2'd0, 32'h5, 32'h5, 2'd1, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd6, M},
      '{4'd6, 2'd0, 32'h0, 32'h0, 2'd2, 20'hFFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd6, M},
      '{4'd11, 2'd0, 32'h0, 32'h0, 2'd2, 20'hFFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd6, 32'h0},
      // R5 predicate merge
      '{4'd1, 2'd0, 32'h0, 32'h1, 2'd0, 20'h0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'd5, 32'h0},
      '{4'd1, 2'd0, 32'h1, 32'h0, 2'd0, 20'h0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd5, M},
      '{4'd2, 2'd0, 32'h2, 32'h2, 2'd0, 20'h0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd5, 32'h0},
      '{4'd2, 2'd0, 32'h2, 32'h3, 2'd0, 20'h0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd5, M},
      // R7 constant tests
      '{4'd0, 2'd0, 32'h7, 32'h7, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd7, 32'h0},
      '{4'd7, 2'd0, 32'h7, 32'h8, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd7, M},
      '{4'd7, 2'd0, 32'h7, 32'h8, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd4, F1},
      // R1 remaining unsigned-only and signed relations
      '{4'd9, 2'd0, 32'h5, 32'h5, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd1, M},
      '{4'd10, 2'd0, 32'h6, 32'h5, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd1, M},
      '{4'd3, 2'd0, 32'h5, 32'h6, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd1, M},
      // R8 extended high-word compares
      '{4'd3, 2'd0, 32'h1, 32'h1, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 8'd8, M},
      '{4'd3, 2'd0, 32'h1, 32'h1, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0110, 8'd8, M},
      '{4'd2, 2'd0, 32'h1, 32'h1, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0010, 8'd8, 32'h0},
      '{4'd4, 2'd0, 32'h1, 32'h1, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0010, 8'd8, M},
      '{4'd1, 2'd0, 32'hFFFF_FFFF, 32'h0, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0110, 8'd8, M},
      '{4'd8, 2'd0, 32'hFFFF_FFFF, 32'h0, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0110, 8'd8, 32'h0},
      '{4'd2, 2'd0, 32'h9, 32'h9, 2'd0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd8, M},
      // R6 immediate edge values
      '{4'd6, 2'd0, 32'h0007_FFFF, 32'h0, 2'd2, 20'h7FFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd6, M},
      '{4'd2, 2'd0, 32'hFFF8_0000, 32'h0, 2'd2, 20'h80000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd6, M}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input vec_t v, input logic we);
      @(negedge clk);
      test_code  = v.tst;
      fmt_sel    = v.fmt;
      opa        = v.a;
      opb_sel    = v.bsel;
      opb_reg    = (v.bsel == 2'd1 || v.bsel == 2'd2) ? ~v.b : v.b;
      opb_const  = (v.bsel == 2'd1) ? v.b : 32'hA5A5_5A5A;
      opb_imm    = v.imm;
      bool_op    = v.bop;
      pred_in    = v.pr;
      pred_inv   = v.pinv;
      float_mode = v.flt;
      ext_mode   = v.ext;
      cc_in      = v.ccin;
      cc_we      = we;
      in_valid   = 1'b1;
      @(negedge clk);
      in_valid   = 1'b0;
      cc_we      = 1'b0;
   endtask

   function automatic vec_t mk(input logic [3:0] t, input logic [1:0] f,
                               input logic [31:0] a, input logic [31:0] b);
      vec_t v;
      v = '0;
      v.tst = t; v.fmt = f; v.a = a; v.b = b;
      return v;
   endfunction

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11 out_valid", {31'b0, out_valid}, 32'h0);
      check("R11 out_result", out_result, 32'h0);
      check("R11 cc_out", {28'b0, cc_out}, 32'h0);
      check("R11 out_illegal", {31'b0, out_illegal}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         send(VECS[i], 1'b0);
         checks++;
         if (out_result !== VECS[i].exp || out_valid !== 1'b1 || out_illegal !== 1'b0) begin
            errors++;
            $display("FAIL R%0d vector %0d: actual %h v%b i%b expected %h", VECS[i].rq, i,
                     out_result, out_valid, out_illegal, VECS[i].exp);
         end
      end

      // R10: strobe drops and result holds when idle
      @(negedge clk);
      check("R10 valid low when idle", {31'b0, out_valid}, 32'h0);
      check("R10 result held", out_result, M);

      // R9: condition-code writes
      send(mk(4'd1, 2'd0, 32'h1, 32'h2), 1'b1);
      check("R9 cc on true", {28'b0, cc_out}, 32'h8);
      send(mk(4'd1, 2'd0, 32'h2, 32'h1), 1'b1);
      check("R9 cc on false", {28'b0, cc_out}, 32'h4);
      send(mk(4'd7, 2'd0, 32'h0, 32'h0), 1'b0);
      check("R9 cc held without write", {28'b0, cc_out}, 32'h4);

      // R3: signed format with unsigned-only test, and reserved code
      send(mk(4'd8, 2'd2, 32'h0, 32'h5), 1'b1);
      check("R3 illegal flag", {31'b0, out_illegal}, 32'h1);
      check("R3 illegal result", out_result, 32'h0);
      check("R3 cc unchanged", {28'b0, cc_out}, 32'h4);
      send(mk(4'd13, 2'd0, 32'h0, 32'h0), 1'b1);
      check("R3 reserved code flag", {31'b0, out_illegal}, 32'h1);
      check("R3 reserved code cc", {28'b0, cc_out}, 32'h4);
      // R2: explicit signed with signed test stays legal
      send(mk(4'd1, 2'd2, 32'hFFFF_FFFF, 32'h0), 1'b0);
      check("R2 explicit signed", out_result, M);
      check("R2 explicit signed legal", {31'b0, out_illegal}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule